// File: doc/BRIEF.md
# Byte-wide SPI master with held chip select

This block is a register-driven SPI master that moves one byte per transfer. Software first programs a 16-bit control word. The word chooses a clock-rate setting, one of three slave select lines, whether the select stays asserted after the byte, an optional completion interrupt and a bus enable. Writing a byte to the data register then starts an 8-bit exchange in SPI mode 0, most significant bit first. The byte shifted in from the slave can be read back from the data register once the transfer is over.

Chip select can be kept low across several single-byte transfers. Software can therefore build a multi-byte command or response from a series of data writes. It then ends the sequence with a control write that clears the hold bit or the enable bit. Software watches a busy bit in the control word or takes a one-cycle interrupt pulse when a byte completes.

Top module: `spi_byte_master`

## Requirements
- R1: The SCK half-period is HALF_BASE << rate system clock cycles, where rate is control bits 1:0. Each step of the setting halves the SCK frequency, and a whole byte takes 16 half-periods.
- R2: Control readback gives the rate in bits 1:0, busy in bit 7, the device in bits 9:8, hold in bit 11, interrupt enable in bit 14 and bus enable in bit 15. Every other bit, 13:12 included, reads 0. Busy reads 1 from the cycle after the starting data write until the byte completes.
- R3: Device values 0, 1 and 2 drive cs_n[0], cs_n[1] and cs_n[2] low respectively while chip select is active. Value 3 drives none, and at most one line is ever low.
- R4: Chip select becomes active when a transfer starts. With hold (bit 11) at 0 it is released in the cycle busy clears, and with hold at 1 it stays active. An idle control write with hold at 0 or enable at 0 releases it.
- R5: A data write while bus enable (bit 15) is 0 starts no transfer and leaves SCK, chip select and busy unchanged.
- R6: Transfers use mode 0. SCK idles low. MOSI carries the written byte MSB first and changes only as SCK falls. MISO is sampled on each SCK rise, and the 8 sampled bits, MSB first, can be read from the data register in the cycle busy clears.
- R7: irq is high for exactly one cycle, the first cycle with busy at 0 after a transfer, and only when bit 14 is set.
- R8: While busy, writes to the control register and to the data register are both ignored.
- R9: After reset the control readback is 0, the data readback is 0, SCK and irq are low and all cs_n lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control register |
| data_we | input | 1 | Write strobe for the data register, starts a transfer |
| wdata | input | 16 | Write data; the data register uses bits 7:0 |
| ctl_rdata | output | 16 | Control and status readback |
| data_rdata | output | 8 | Last received byte |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| cs_n | output | 3 | Active-low slave selects |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with HALF_BASE at 2, so the half-period runs from 2 to 16 system cycles. This puts all four rate settings within a short run, with every bit of a slow byte still spanning several cycles. At these small divisors a reference model that runs one cycle at a time can compare SCK, MOSI, chip select, busy and irq in every cycle. Held-select sequences, ignored writes during a transfer and the unused device value all fit in one run as well.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int HALF_BASE = 2,
  parameter int NUM_DEV   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               data_we,
  input  logic [15:0]        wdata,
  output logic [15:0]        ctl_rdata,
  output logic [7:0]         data_rdata,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_DEV-1:0] cs_n,
  output logic               irq
);
  localparam int DIVW = $clog2(HALF_BASE * 8) + 1;

  logic [1:0]      rate_q, dev_q;
  logic            hold_q, ie_q, en_q;
  logic            busy_q, cs_act_q, sck_q, irq_q;
  logic [DIVW-1:0] div_q, half_len;
  logic [3:0]      hcnt_q;
  logic [7:0]      tx_q, rx_q, rdata_q;
  logic            tick;

  assign half_len = DIVW'(HALF_BASE) << rate_q;
  assign tick     = busy_q && (div_q == half_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q   <= '0;
      dev_q    <= '0;
      hold_q   <= 1'b0;
      ie_q     <= 1'b0;
      en_q     <= 1'b0;
      busy_q   <= 1'b0;
      cs_act_q <= 1'b0;
      sck_q    <= 1'b0;
      irq_q    <= 1'b0;
      div_q    <= '0;
      hcnt_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rdata_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      if (!busy_q) begin
        if (ctl_we) begin
          rate_q <= wdata[1:0];
          dev_q  <= wdata[9:8];
          hold_q <= wdata[11];
          ie_q   <= wdata[14];
          en_q   <= wdata[15];
          if (!wdata[11] || !wdata[15]) cs_act_q <= 1'b0;
        end else if (data_we && en_q) begin
          busy_q   <= 1'b1;
          cs_act_q <= 1'b1;
          sck_q    <= 1'b0;
          div_q    <= '0;
          hcnt_q   <= '0;
          tx_q     <= wdata[7:0];
        end
      end else if (tick) begin
        div_q  <= '0;
        hcnt_q <= hcnt_q + 4'd1;
        sck_q  <= ~sck_q;
        if (!hcnt_q[0]) rx_q <= {rx_q[6:0], miso};
        else            tx_q <= {tx_q[6:0], 1'b0};
        if (hcnt_q == 4'd15) begin
          busy_q  <= 1'b0;
          rdata_q <= rx_q;
          irq_q   <= ie_q;
          if (!hold_q) cs_act_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
    assign cs_n[i] = ~(cs_act_q && (dev_q == 2'(i)));
  end

  assign sck        = sck_q;
  assign mosi       = tx_q[7];
  assign irq        = irq_q;
  assign data_rdata = rdata_q;
  assign ctl_rdata  = {en_q, ie_q, 2'b00, hold_q, 1'b0, dev_q, busy_q, 5'b00000, rate_q};

  p_sck_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  p_cs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_irq_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!busy_q && $past(busy_q)));
  p_no_start_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && data_we && !ctl_we && !en_q) |=> !busy_q);
  p_ctl_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(rate_q) && $stable(dev_q) && $stable(hold_q) && $stable(en_q)));
  p_cs_during_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cs_act_q);
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, data_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] ctl_rdata;
  logic [7:0]  data_rdata;
  logic        sck, mosi, miso, irq;
  logic [2:0]  cs_n;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] slave_byte = 8'h00;

  logic [1:0] m_rate, m_dev;
  logic       m_hold, m_ie, m_en, m_busy, m_csact, m_irq;
  logic [7:0] m_tx, m_rxpat, m_data;
  int         m_cnt;

  function automatic int hl();
    return HB << m_rate;
  endfunction

  assign miso = m_busy ? m_rxpat[7 - ((m_cnt / hl()) / 2)] : 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master #(.HALF_BASE(HB), .NUM_DEV(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .data_we(data_we), .wdata(wdata),
    .ctl_rdata(ctl_rdata), .data_rdata(data_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rate <= 0; m_dev <= 0; m_hold <= 0; m_ie <= 0; m_en <= 0;
      m_busy <= 0; m_csact <= 0; m_irq <= 0; m_tx <= 0; m_rxpat <= 0;
      m_data <= 0; m_cnt <= 0;
    end else begin
      m_irq <= 1'b0;
      if (m_busy) begin
        if (m_cnt + 1 == 16 * hl()) begin
          m_busy <= 1'b0;
          m_data <= m_rxpat;
          m_irq  <= m_ie;
          if (!m_hold) m_csact <= 1'b0;
        end
        m_cnt <= m_cnt + 1;
      end else if (ctl_we) begin
        m_rate <= wdata[1:0]; m_dev <= wdata[9:8]; m_hold <= wdata[11];
        m_ie <= wdata[14]; m_en <= wdata[15];
        if (!wdata[11] || !wdata[15]) m_csact <= 1'b0;
      end else if (data_we && m_en) begin
        m_busy <= 1'b1; m_cnt <= 0; m_tx <= wdata[7:0];
        m_rxpat <= slave_byte; m_csact <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [15:0] exp_ctl;
      logic [2:0]  exp_cs;
      logic        exp_sck;
      exp_ctl = {m_en, m_ie, 2'b00, m_hold, 1'b0, m_dev, m_busy, 5'b00000, m_rate};
      exp_cs  = 3'b111;
      if (m_csact && m_dev != 2'd3) exp_cs[m_dev] = 1'b0;
      exp_sck = m_busy && ((m_cnt / hl()) % 2 == 1);
      chk(ctl_rdata == exp_ctl, "R2/R8 control readback", ctl_rdata, exp_ctl);
      chk(cs_n == exp_cs, "R3/R4 chip select", cs_n, exp_cs);
      chk(sck == exp_sck, "R1/R6 sck", sck, exp_sck);
      chk(irq == m_irq, "R7 irq", irq, m_irq);
      chk(data_rdata == m_data, "R6 received byte", data_rdata, m_data);
      if (m_busy)
        chk(mosi == m_tx[7 - ((m_cnt / hl()) / 2)], "R6 mosi", mosi, m_tx[7 - ((m_cnt / hl()) / 2)]);
    end
  end

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_we = 1'b1; wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] b, input logic [7:0] sb);
    @(negedge clk); slave_byte = sb; data_we = 1'b1; wdata = {8'h00, b};
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] cw(bit en, bit ie, bit hold, logic [1:0] dev, logic [1:0] rate);
    return {en, ie, 2'b00, hold, 1'b0, dev, 1'b0, 5'b00000, rate};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(ctl_rdata == 16'h0, "R9 ctl reset", ctl_rdata, 0);
    chk(data_rdata == 8'h0, "R9 data reset", data_rdata, 0);
    chk(cs_n == 3'b111, "R9 cs reset", cs_n, 3'b111);
    chk(sck == 1'b0 && irq == 1'b0, "R9 sck/irq reset", {sck, irq}, 0);
    rst_n = 1'b1;
    // R5: bus disabled, data write starts nothing
    wr_ctl(cw(0, 1, 1, 2'd0, 2'd0));
    wr_data(8'hFF, 8'h55);
    repeat (10) @(negedge clk);
    chk(ctl_rdata[7] == 1'b0, "R5 no start when disabled", ctl_rdata[7], 0);
    // R1 R6: rate 0, device 0, no hold, no irq
    wr_ctl(cw(1, 0, 0, 2'd0, 2'd0));
    wr_data(8'hA5, 8'h3C);
    wait_idle();
    chk(data_rdata == 8'h3C, "R6 first byte", data_rdata, 8'h3C);
    // R4 R7 R8: device 1, rate 1, hold, irq on; writes during busy ignored
    wr_ctl(cw(1, 1, 1, 2'd1, 2'd1));
    wr_data(8'h81, 8'hC3);
    repeat (5) @(negedge clk);
    wr_ctl(cw(0, 0, 0, 2'd2, 2'd3));
    wr_data(8'h00, 8'h00);
    wait_idle();
    chk(cs_n == 3'b101, "R4 select held", cs_n, 3'b101);
    wr_data(8'h7E, 8'h96);
    wait_idle();
    chk(data_rdata == 8'h96, "R6 held second byte", data_rdata, 8'h96);
    wr_ctl(cw(1, 1, 0, 2'd1, 2'd1));
    @(negedge clk);
    chk(cs_n == 3'b111, "R4 release by hold clear", cs_n, 3'b111);
    // R3: device 2 at rate 2, then device 3 at rate 3
    wr_ctl(cw(1, 1, 0, 2'd2, 2'd2));
    wr_data(8'h5A, 8'h0F);
    wait_idle();
    wr_ctl(cw(1, 0, 1, 2'd3, 2'd3));
    wr_data(8'hC0, 8'hF1);
    wait_idle();
    chk(data_rdata == 8'hF1, "R3 device 3 byte", data_rdata, 8'hF1);
    // R4: enable clear releases a held select
    wr_ctl(cw(1, 0, 1, 2'd0, 2'd0));
    wr_data(8'h11, 8'h22);
    wait_idle();
    wr_ctl(cw(0, 0, 1, 2'd0, 2'd0));
    @(negedge clk);
    chk(cs_n == 3'b111, "R4 release by enable clear", cs_n, 3'b111);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule